// File: doc/BRIEF.md
# Rank Decoder with Spare Substitution

This block takes a channel-relative DRAM address that has already been normalized and finds the rank (chip select) that owns it. Each memory controller has a set of chip-select base registers and a set of mask registers, and one mask register serves two neighbouring chip selects. A chip select claims the address when it is enabled and the address agrees with its base on every bit that the mask does not exclude. A configurable valid-bit pattern restricts which bits take part in the comparison.

If online sparing has already copied a failed rank onto a spare, a hit on the failed rank is redirected to the spare rank. The block reports whether any rank matched, the rank number, and the DIMM slot, which is the rank number halved. In ganged operation the registers of controller 0 serve every channel. One request is accepted per cycle, and its result appears registered on the next cycle.

Top module: `cs_rank_matcher`

## Requirements
- R1: A chip select takes part in matching only when bit 0 of its base register is 1.
- R2: Chip selects 2k and 2k+1 both use mask register k. A 1 in that mask excludes the corresponding comparison bit.
- R3: Register bit i stands for address bit i+8. The address matches when, for every bit i that is 1 in the valid-bit pattern and 0 in the mask, address bit i+8 equals base bit i. A 0 in the valid-bit pattern removes that bit from the comparison.
- R4: When several enabled chip selects match, the lowest-numbered one is reported.
- R5: The spare-control swap flag for channel c is bit 1+2c, and the failed-rank field for channel c is bits 4+4c to 6+4c. Channel c is the channel input, in ganged mode as well. When the swap flag is set and the matched rank equals the failed rank, the reported rank is the lowest chip select whose base register has bit 1 set.
- R6: No substitution happens when the swap flag is clear or when the matched rank differs from the failed rank. If no base register has bit 1 set, the matched rank is reported unchanged.
- R7: When ganged is 1, the registers of controller 0 are used for any channel input. Otherwise the registers of the controller given by the channel input are used.
- R8: The DIMM index equals the reported chip-select number shifted right by one.
- R9: When no chip select matches, found is 0 and both the chip-select and DIMM outputs are 0.
- R10: A request presented with in_valid on one clock edge has its result and out_valid on the next edge. Without a request, out_valid falls and the other outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Request strobe |
| chan_addr_i | input | ADDR_W (40) | Normalized channel address |
| chan_sel_i | input | CH_W (1) | Channel number |
| ganged_i | input | 1 | Ganged mode: use controller 0 registers |
| cs_base_i | input | NUM_CH*NUM_CS*REG_W (512) | Base register images, controller-major, chip select-minor |
| cs_mask_i | input | NUM_CH*NUM_CS/2*REG_W (256) | Mask register images, controller-major |
| valid_bits_i | input | REG_W (32) | Valid-bit pattern for base, mask and address |
| spare_ctrl_i | input | SPARE_W (32) | Spare-control word |
| out_valid_o | output | 1 | Result strobe |
| found_o | output | 1 | A rank matched |
| cs_o | output | CS_W (3) | Reported chip select |
| dimm_o | output | CS_W-1 (2) | Reported DIMM index |

## Verification
Every result is due exactly one cycle after its request edge. A driver task applies the request, works out the expected rank from the requirements, and queues it. A monitor samples on the falling edge after the next rising edge, checks each out_valid result against the head of the queue, and flags any unexpected result. The register images change only after the capturing edge, so each expectation is computed from the same register state that the design latches. After the last request, one extra sampled cycle confirms that out_valid has dropped.

// File: rtl/csm_pkg.sv
package csm_pkg;
    // register bit i of base/mask corresponds to address bit i + ADDR_SHIFT
    localparam int unsigned ADDR_SHIFT   = 8;
    // spare-control layout per channel c
    localparam int unsigned SWAP_BASE    = 1;
    localparam int unsigned SWAP_STRIDE  = 2;
    localparam int unsigned BAD_BASE     = 4;
    localparam int unsigned BAD_STRIDE   = 4;
    // base register flag positions
    localparam int unsigned EN_BIT       = 0;
    localparam int unsigned SPARE_BIT    = 1;
endpackage

// File: rtl/cs_lane.sv
module cs_lane #(
    parameter int unsigned REG_W = 32
) (
    input  logic [REG_W-1:0] addr_sh_i,
    input  logic [REG_W-1:0] base_i,
    input  logic [REG_W-1:0] mask_i,
    input  logic [REG_W-1:0] vbits_i,
    output logic             match_o
);
    import csm_pkg::*;

    logic [REG_W-1:0] diff;

    always_comb begin
        diff    = (addr_sh_i ^ base_i) & vbits_i & ~mask_i;
        match_o = base_i[EN_BIT] && (diff == '0);
    end

    // R1: a disabled lane never claims an address
    always_comb begin
        if (match_o === 1'b1) begin
            p_lane_enabled_r1: assert (base_i[EN_BIT] === 1'b1);
        end
    end
endmodule

// File: rtl/cs_first.sv
module cs_first #(
    parameter int unsigned N = 8,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end

    // R4: the reported index is a requesting one, and nothing lower requests
    always_comb begin
        if (found_o === 1'b1) begin
            p_pick_valid_r4: assert (req_i[idx_o] === 1'b1);
            p_pick_lowest_r4: assert ((req_i & ((N'(1) << idx_o) - N'(1))) == '0);
        end
    end
endmodule

// File: rtl/cs_rank_matcher.sv
module cs_rank_matcher #(
    parameter int unsigned NUM_CS  = 8,
    parameter int unsigned NUM_CH  = 2,
    parameter int unsigned REG_W   = 32,
    parameter int unsigned ADDR_W  = 40,
    parameter int unsigned SPARE_W = 32,
    localparam int unsigned CS_W     = $clog2(NUM_CS),
    localparam int unsigned CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned NUM_MASK = NUM_CS / 2,
    localparam int unsigned DIMM_W   = CS_W - 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             in_valid_i,
    input  logic [ADDR_W-1:0]                chan_addr_i,
    input  logic [CH_W-1:0]                  chan_sel_i,
    input  logic                             ganged_i,
    input  logic [NUM_CH*NUM_CS*REG_W-1:0]   cs_base_i,
    input  logic [NUM_CH*NUM_MASK*REG_W-1:0] cs_mask_i,
    input  logic [REG_W-1:0]                 valid_bits_i,
    input  logic [SPARE_W-1:0]               spare_ctrl_i,
    output logic                             out_valid_o,
    output logic                             found_o,
    output logic [CS_W-1:0]                  cs_o,
    output logic [DIMM_W-1:0]                dimm_o
);
    import csm_pkg::*;

    typedef struct packed {
        logic              vld;
        logic              hit;
        logic [CS_W-1:0]   cs;
        logic [DIMM_W-1:0] dimm;
    } res_t;

    res_t res_d, res_q;

    logic [CH_W-1:0]  ctrl;
    logic [REG_W-1:0] addr_sh;
    logic [NUM_CS-1:0] lane_hit;
    logic [NUM_CS-1:0] spare_flag;
    logic [REG_W-1:0] base_sel [NUM_CS];
    logic [REG_W-1:0] mask_sel [NUM_CS];

    logic            first_found, spare_found;
    logic [CS_W-1:0] first_idx, spare_idx;
    logic            swap_done;
    logic [CS_W-1:0] bad_rank;
    logic            remap;

    always_comb begin
        ctrl    = ganged_i ? '0 : chan_sel_i;
        addr_sh = REG_W'(chan_addr_i >> ADDR_SHIFT);
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_lane
        always_comb begin
            base_sel[g]   = cs_base_i[(int'(ctrl) * NUM_CS + g) * REG_W +: REG_W];
            mask_sel[g]   = cs_mask_i[(int'(ctrl) * NUM_MASK + g / 2) * REG_W +: REG_W];
            spare_flag[g] = base_sel[g][SPARE_BIT];
        end

        cs_lane #(.REG_W(REG_W)) u_lane (
            .addr_sh_i (addr_sh),
            .base_i    (base_sel[g]),
            .mask_i    (mask_sel[g]),
            .vbits_i   (valid_bits_i),
            .match_o   (lane_hit[g])
        );
    end

    cs_first #(.N(NUM_CS)) u_first_hit (
        .req_i   (lane_hit),
        .found_o (first_found),
        .idx_o   (first_idx)
    );

    cs_first #(.N(NUM_CS)) u_first_spare (
        .req_i   (spare_flag),
        .found_o (spare_found),
        .idx_o   (spare_idx)
    );

    always_comb begin
        swap_done = spare_ctrl_i[SWAP_BASE + SWAP_STRIDE * int'(chan_sel_i)];
        bad_rank  = spare_ctrl_i[BAD_BASE + BAD_STRIDE * int'(chan_sel_i) +: CS_W];
        remap     = swap_done && (bad_rank == first_idx) && spare_found;
    end

    always_comb begin
        res_d     = res_q;
        res_d.vld = in_valid_i;
        if (in_valid_i) begin
            res_d.hit  = first_found;
            res_d.cs   = '0;
            if (first_found) begin
                res_d.cs = remap ? spare_idx : first_idx;
            end
            res_d.dimm = res_d.cs[CS_W-1:1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid_o = res_q.vld;
    assign found_o     = res_q.hit;
    assign cs_o        = res_q.cs;
    assign dimm_o      = res_q.dimm;

    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o);

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> (!out_valid_o && $stable(cs_o) && $stable(found_o)));

    p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !found_o) |-> (cs_o == '0 && dimm_o == '0));

    p_dimm_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (dimm_o == cs_o[CS_W-1:1]));

    p_remap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && first_found && remap) |=> (found_o && cs_o[0] == $past(spare_idx[0])));
endmodule

// File: tb/tb_cs_rank_matcher.sv
module tb_cs_rank_matcher;
    localparam int CLK_PERIOD = 10;
    localparam int NCS = 8;
    localparam int NCH = 2;
    localparam int RW  = 32;
    localparam int AW  = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [AW-1:0] addr = '0;
    logic chan = 1'b0;
    logic ganged = 1'b0;
    logic [RW-1:0] base_r [NCH][NCS];
    logic [RW-1:0] mask_r [NCH][NCS/2];
    logic [RW-1:0] vbits = 32'hFFFF_FFE0;
    logic [31:0] spare = '0;
    logic [NCH*NCS*RW-1:0] base_flat;
    logic [NCH*NCS/2*RW-1:0] mask_flat;
    logic out_valid, found;
    logic [2:0] cs;
    logic [1:0] dimm;

    int n_tests = 0;
    int n_fail  = 0;
    logic [5:0] exp_q [$];
    string      tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            for (int s = 0; s < NCS; s++) base_flat[(c*NCS+s)*RW +: RW] = base_r[c][s];
            for (int m = 0; m < NCS/2; m++) mask_flat[(c*(NCS/2)+m)*RW +: RW] = mask_r[c][m];
        end
    end

    cs_rank_matcher dut (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .chan_addr_i(addr),
        .chan_sel_i(chan), .ganged_i(ganged), .cs_base_i(base_flat),
        .cs_mask_i(mask_flat), .valid_bits_i(vbits), .spare_ctrl_i(spare),
        .out_valid_o(out_valid), .found_o(found), .cs_o(cs), .dimm_o(dimm)
    );

    function automatic logic [5:0] model(logic [AW-1:0] a, logic ch, logic g);
        int ctl;
        logic hit;
        int sel;
        logic [RW-1:0] sh;
        ctl = g ? 0 : int'(ch);
        hit = 1'b0;
        sel = 0;
        sh  = a[AW-1:8];
        for (int s = 0; s < NCS; s++) begin
            if (!hit && base_r[ctl][s][0] &&
                (((sh ^ base_r[ctl][s]) & vbits & ~mask_r[ctl][s/2]) == '0)) begin
                hit = 1'b1;
                sel = s;
            end
        end
        if (hit && spare[1 + 2*int'(ch)] && (int'(spare[4 + 4*int'(ch) +: 3]) == sel)) begin
            for (int s = NCS - 1; s >= 0; s--) if (base_r[ctl][s][1]) sel = s;
        end
        return {hit, 3'(sel), 2'(sel / 2)};
    endfunction

    task automatic apply(logic [AW-1:0] a, logic ch, logic g, string tag);
        @(negedge clk);
        addr = a; chan = ch; ganged = g; in_valid = 1'b1;
        exp_q.push_back(model(a, ch, g));
        tag_q.push_back(tag);
        @(posedge clk);
        #1;
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R10: unexpected result act cs=%0d found=%0b exp none", cs, found);
            end else begin
                logic [5:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({found, cs, dimm} !== e) begin
                    n_fail++;
                    $display("FAIL %s: act found=%0b cs=%0d dimm=%0d exp found=%0b cs=%0d dimm=%0d",
                             t, found, cs, dimm, e[5], e[4:2], e[1:0]);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: act hung exp finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            for (int s = 0; s < NCS; s++) base_r[c][s] = '0;
            for (int m = 0; m < NCS/2; m++) mask_r[c][m] = 32'h0000_3FE0;
        end
        base_r[0][0] = 32'h0000_0001;
        base_r[0][1] = 32'h0000_4001;
        base_r[0][2] = 32'h0000_8001;
        base_r[0][3] = 32'h0000_C001;
        base_r[0][4] = 32'h0001_0000;  // disabled
        base_r[0][5] = 32'h0001_4001;
        base_r[0][6] = 32'h0001_4001;  // overlaps cs5
        base_r[0][7] = 32'h0000_0002;  // spare rank, not enabled
        base_r[1][0] = 32'h0004_0001;
        base_r[1][3] = 32'h0000_0002;  // spare rank on controller 1

        repeat (2) @(posedge clk);
        #1;
        n_tests++;
        if (out_valid !== 1'b0 || found !== 1'b0 || cs !== 3'd0) begin
            n_fail++;
            $display("FAIL R10 reset: act v=%0b f=%0b cs=%0d exp 0 0 0", out_valid, found, cs);
        end
        rst_n = 1'b1;

        apply(40'h00_0000_1234, 1'b0, 1'b0, "R3 cs0 basic");
        apply(40'h00_0040_0000, 1'b0, 1'b0, "R2 cs1 shared mask");
        apply(40'h00_00C0_1000, 1'b0, 1'b0, "R8 cs3 dimm1");
        apply(40'h00_0100_0000, 1'b0, 1'b0, "R1 disabled cs4 miss R9");
        apply(40'h00_0140_0000, 1'b0, 1'b0, "R4 overlap lowest wins");
        mask_r[0][2] = 32'h0000_7FE0;
        apply(40'h00_0100_0000, 1'b0, 1'b0, "R2 wide mask2 serves cs5");
        mask_r[0][2] = 32'h0000_3FE0;
        apply(40'h00_1000_1234, 1'b0, 1'b0, "R3 bit28 compared miss");
        vbits = 32'hFFEF_FFE0;
        apply(40'h00_1000_1234, 1'b0, 1'b0, "R3 bit28 excluded hit");
        vbits = 32'hFFFF_FFE0;
        apply(40'h00_0400_0000, 1'b1, 1'b0, "R7 unganged ctrl1");
        apply(40'h00_0400_0000, 1'b1, 1'b1, "R7 ganged ctrl0 miss");
        apply(40'h00_0040_0000, 1'b1, 1'b1, "R7 ganged ctrl0 cs1");
        spare = 32'h0000_0012;
        apply(40'h00_0040_0000, 1'b0, 1'b0, "R5 cs1 remapped to cs7");
        apply(40'h00_0000_1234, 1'b0, 1'b0, "R6 other rank kept");
        spare = 32'h0000_0010;
        apply(40'h00_0040_0000, 1'b0, 1'b0, "R6 swap flag clear");
        spare = 32'h0000_0008;
        apply(40'h00_0400_0000, 1'b1, 1'b0, "R5 ch1 remapped to cs3");
        spare = 32'h0000_0002;
        apply(40'h00_0400_0000, 1'b1, 1'b0, "R6 ch0 swap ignored on ch1");
        base_r[0][7] = 32'h0000_0000;
        spare = 32'h0000_0012;
        apply(40'h00_0040_0000, 1'b0, 1'b0, "R6 no spare rank kept");

        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 idle: act out_valid=%0b exp 0", out_valid);
        end
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R10 missing results: act %0d pending exp 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule